// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Flag Word

This block is the arithmetic core of a small 16-bit processor's execution stage. Instruction decode hands it two operands and a 3-bit operation code. The block then forms a result of the configured width from them, together with three combinational indications: carry/borrow, result-is-zero and unsigned operand-A-above-operand-B. The datapath width is a parameter `N`, which defaults to 16. Operation code 000 adds, 001 subtracts B from A and 010 decrements A by one. Code 011 is bitwise AND, 100 is bitwise OR and 101 inverts A. Codes 110 and 111 are idle codes.

A 16-bit flag word sits beside the datapath. On a clock edge where the flag-write strobe is high, the status fields take their new values from the operation in progress. The status fields are carry, parity, nibble carry, zero, sign and overflow. The three control fields (direction, interrupt enable, trap) are separate from that path. They change only through dedicated set and clear strobes.

The datapath is purely combinational and carries no stream traffic. It therefore has no valid/ready handshake and no back-pressure: the outputs follow the inputs in the same cycle, and the caller decides when to latch flags through `flag_we`.

Top module: `alu_flag_unit`

## Requirements
- R1: Results are taken modulo 2^N for each code: 000 gives A+B, 001 gives A-B, 010 gives A-1, 011 gives A AND B, 100 gives A OR B, 101 gives NOT A.
- R2: `carry_o` is the carry out of bit N-1 for 000. It is a borrow for 001 (A < B) and for 010 (A equal to 0). It is 0 for codes 011, 100 and 101.
- R3: `zero_o` is 1 exactly when `result` is all zeros. `a_gt_b_o` is 1 exactly when A > B unsigned, for every code.
- R4: Codes 110 and 111 drive `result` and `carry_o` to 0 and leave every status field of the flag word unchanged, even with `flag_we` high.
- R5: Flag word layout: bit 0 carry, bit 2 parity, bit 4 nibble carry, bit 6 zero, bit 7 sign, bit 8 trap, bit 9 interrupt enable, bit 10 direction, bit 11 overflow. All other bits are always 0, and reset clears the whole word.
- R6: On a rising clock edge with `flag_we` high and a code from 000 to 101, the status fields take the values of the current operation. Bit 0 takes `carry_o`, bit 6 takes `zero_o` and bit 7 takes result bit N-1. With `flag_we` low, the status fields hold.
- R7: The captured parity bit (bit 2) is 1 when bits 7..0 of the result hold an even number of ones.
- R8: The captured nibble-carry bit (bit 4) is the carry out of bit 3 for 000. It is the borrow out of bit 3 for 001 and 010. It is 0 for the logic codes.
- R9: The captured overflow bit (bit 11) marks two's-complement overflow of 000, 001 and 010. It is 0 for the logic codes.
- R10: `ctl_set`/`ctl_clr` bit k drives flag bit 8+k to 1/0 on the clock edge, so index 0 is trap, 1 is interrupt enable and 2 is direction. Clear takes priority over set. These bits hold when their strobes are low, whatever `flag_we` and `fsel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag word |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa | input | N | Operand A |
| opb | input | N | Operand B |
| fsel | input | 3 | Operation code |
| flag_we | input | 1 | Capture status fields at the next edge |
| ctl_set | input | 3 | Set strobes for trap / interrupt enable / direction |
| ctl_clr | input | 3 | Clear strobes, same bit order, priority over set |
| result | output | N | Operation result |
| carry_o | output | 1 | Carry or borrow out |
| zero_o | output | 1 | Result is zero |
| a_gt_b_o | output | 1 | A above B, unsigned |
| flags_o | output | 16 | Flag word |

## Verification
Some properties are checked by the bound assertions on every cycle:
- the reserved flag bits stay at zero;
- the status fields hold when the write strobe is low or an idle code is presented;
- carry, zero and sign captured in the flag word match the combinational outputs of the previous cycle;
- the control bits hold without strobes and fall after a clear.

The arithmetic correctness of the result can only be shown by the bench's sweep. The sweep covers every A against a spread of B values in a narrow configuration and compares against arithmetic expectations. The same applies to parity, nibble carry and signed overflow. Clear-over-set priority on a single control bit is also shown by the bench.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_DEC  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_NOT  = 3'b101,
    OP_IDL6 = 3'b110,
    OP_IDL7 = 3'b111
  } alu_op_e;

  localparam int FLAG_W   = 16;
  localparam int CF_BIT   = 0;
  localparam int PF_BIT   = 2;
  localparam int AF_BIT   = 4;
  localparam int ZF_BIT   = 6;
  localparam int SF_BIT   = 7;
  localparam int CTL_BASE = 8;   // trap, interrupt enable, direction follow
  localparam int CTL_W    = 3;
  localparam int OF_BIT   = 11;

  localparam logic [FLAG_W-1:0] STATUS_MASK = 16'h08D5;
  localparam logic [FLAG_W-1:0] CTL_MASK    = 16'h0700;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zero;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_flag_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  alu_op_e      op,
  output logic [N-1:0] y,
  output logic         carry,
  output logic         aux,
  output logic         ovf,
  output logic         op_valid
);
  localparam logic [N:0] ONE_W   = (N+1)'(1);
  localparam int         MSB     = N - 1;

  logic [N:0] wide;
  logic [4:0] nib;

  always_comb begin
    wide     = '0;
    nib      = '0;
    y        = '0;
    carry    = 1'b0;
    aux      = 1'b0;
    ovf      = 1'b0;
    op_valid = 1'b1;
    case (op)
      OP_ADD: begin
        wide  = {1'b0, a} + {1'b0, b};
        nib   = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        y     = wide[N-1:0];
        carry = wide[N];
        aux   = nib[4];
        ovf   = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
      end
      OP_SUB: begin
        wide  = {1'b0, a} - {1'b0, b};
        nib   = {1'b0, a[3:0]} - {1'b0, b[3:0]};
        y     = wide[N-1:0];
        carry = wide[N];
        aux   = nib[4];
        ovf   = (a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]);
      end
      OP_DEC: begin
        wide  = {1'b0, a} - ONE_W;
        nib   = {1'b0, a[3:0]} - 5'd1;
        y     = wide[N-1:0];
        carry = wide[N];
        aux   = nib[4];
        ovf   = a[MSB] & ~wide[MSB];
      end
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NOT:  y = ~a;
      default: op_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cond_gen.sv
module alu_cond_gen
  import alu_flag_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] y,
  output logic         zero,
  output logic         a_gt_b,
  output logic         par,
  output logic         sgn
);
  assign zero   = (y == '0);
  assign a_gt_b = (a > b);
  assign par    = even_ones8(y[7:0]);
  assign sgn    = y[N-1];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              op_valid,
  input  status_t           st_in,
  input  logic [CTL_W-1:0]  ctl_set,
  input  logic [CTL_W-1:0]  ctl_clr,
  output logic [FLAG_W-1:0] flags
);
  status_t          st_q;
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                st_q <= '0;
    else if (we && op_valid)   st_q <= st_in;
  end

  for (genvar k = 0; k < CTL_W; k++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctl_q[k] <= 1'b0;
      else if (ctl_clr[k]) ctl_q[k] <= 1'b0;
      else if (ctl_set[k]) ctl_q[k] <= 1'b1;
    end
  end

  always_comb begin
    flags                              = '0;
    flags[CF_BIT]                      = st_q.cry;
    flags[PF_BIT]                      = st_q.par;
    flags[AF_BIT]                      = st_q.aux;
    flags[ZF_BIT]                      = st_q.zero;
    flags[SF_BIT]                      = st_q.sgn;
    flags[OF_BIT]                      = st_q.ovf;
    flags[CTL_BASE +: CTL_W]           = ctl_q;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic [2:0]   fsel,
  input  logic         flag_we,
  input  logic [2:0]   ctl_set,
  input  logic [2:0]   ctl_clr,
  output logic [N-1:0] result,
  output logic         carry_o,
  output logic         zero_o,
  output logic         a_gt_b_o,
  output logic [15:0]  flags_o
);
  logic    aux, ovf, op_valid, par, sgn;
  status_t st;

  alu_arith_core #(.N(N)) u_core (
    .a(opa), .b(opb), .op(alu_op_e'(fsel)),
    .y(result), .carry(carry_o), .aux(aux), .ovf(ovf), .op_valid(op_valid)
  );

  alu_cond_gen #(.N(N)) u_cond (
    .a(opa), .b(opb), .y(result),
    .zero(zero_o), .a_gt_b(a_gt_b_o), .par(par), .sgn(sgn)
  );

  always_comb begin
    st.cry  = carry_o;
    st.par  = par;
    st.aux  = aux;
    st.zero = zero_o;
    st.sgn  = sgn;
    st.ovf  = ovf;
  end

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .op_valid(op_valid), .st_in(st),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags(flags_o)
  );
endmodule

// File: rtl/alu_flag_checker.sv
module alu_flag_checker
  import alu_flag_pkg::*;
#(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] opa,
  input logic [N-1:0] opb,
  input logic [2:0]   fsel,
  input logic         flag_we,
  input logic [2:0]   ctl_set,
  input logic [2:0]   ctl_clr,
  input logic [N-1:0] result,
  input logic         carry_o,
  input logic         zero_o,
  input logic         a_gt_b_o,
  input logic [15:0]  flags_o
);
  logic idle_code, logic_code;
  assign idle_code  = (fsel[2:1] == 2'b11);
  assign logic_code = (fsel == 3'b011) || (fsel == 3'b100) || (fsel == 3'b101);

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~(STATUS_MASK | CTL_MASK)) == 16'h0);

  assert_idle_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_code |-> (result == '0) && !carry_o);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && idle_code) |=> $stable(flags_o & STATUS_MASK));

  assert_we_low_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_o & STATUS_MASK));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !idle_code) |=> (flags_o[CF_BIT] == $past(carry_o))
      && (flags_o[ZF_BIT] == $past(zero_o)) && (flags_o[SF_BIT] == $past(result[N-1])));

  assert_sub_borrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 3'b001 && a_gt_b_o) |-> !carry_o);

  assert_dec_borrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 3'b010 && opa != '0) |-> !carry_o);

  assert_gt_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_gt_b_o |-> (opa != opb));

  assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && logic_code) |=> !flags_o[OF_BIT] && !flags_o[CF_BIT] && !flags_o[AF_BIT]);

  assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags_o[10:8]));

  assert_ctl_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr != 3'b000) |=> (flags_o[10:8] & $past(ctl_clr)) == 3'b000);
endmodule

bind alu_flag_unit alu_flag_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .fsel(fsel),
  .flag_we(flag_we), .ctl_set(ctl_set), .ctl_clr(ctl_clr), .result(result),
  .carry_o(carry_o), .zero_o(zero_o), .a_gt_b_o(a_gt_b_o), .flags_o(flags_o)
);

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [2:0]   fsel = 3'b000;
  logic         flag_we = 1'b0;
  logic [2:0]   ctl_set = 3'b000, ctl_clr = 3'b000;
  logic [W-1:0] result;
  logic         carry_o, zero_o, a_gt_b_o;
  logic [15:0]  flags_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_unit #(.N(W)) u_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .fsel(fsel),
    .flag_we(flag_we), .ctl_set(ctl_set), .ctl_clr(ctl_clr), .result(result),
    .carry_o(carry_o), .zero_o(zero_o), .a_gt_b_o(a_gt_b_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Expected behaviour for an 8-bit datapath, from the requirements.
  task automatic model(input int op, input int a, input int b,
                       output int y, output int c, output int af,
                       output int ov, output bit valid);
    int s;
    valid = 1; y = 0; c = 0; af = 0; ov = 0;
    case (op)
      0: begin s = a + b; y = s % 256; c = (s > 255); af = ((a % 16) + (b % 16)) > 15;
               s = to_signed(a) + to_signed(b); ov = (s > 127) || (s < -128); end
      1: begin y = (a - b + 256) % 256; c = (a < b); af = (a % 16) < (b % 16);
               s = to_signed(a) - to_signed(b); ov = (s > 127) || (s < -128); end
      2: begin y = (a + 255) % 256; c = (a == 0); af = (a % 16) == 0;
               s = to_signed(a) - 1; ov = (s < -128); end
      3: y = a & b;
      4: y = a | b;
      5: y = 255 - a;
      default: valid = 0;
    endcase
  endtask

  function automatic int status_word(input int y, input int c, input int af, input int ov);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (y >> i) & 1;
    return c | (((ones % 2) == 0) << 2) | (af << 4) | ((y == 0) << 6)
             | ((y >= 128) << 7) | (ov << 11);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int y, c, af, ov, prev, expw;
    bit valid;
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset word", int'(flags_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R6 R7 R8 R9: sweep all codes, every A, B on a spread grid
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          int b = (bi == 15) ? 1 : bi * 17;
          @(negedge clk);
          opa = W'(a); opb = W'(b); fsel = 3'(op); flag_we = 1'b1;
          #1;
          model(op, a, b, y, c, af, ov, valid);
          prev = int'(flags_o) & 'h08D5;
          check(valid ? "R1 result" : "R4 idle result", int'(result), y);
          check("R2 carry", int'(carry_o), c);
          check("R3 zero", int'(zero_o), int'(y == 0));
          check("R3 a_gt_b", int'(a_gt_b_o), int'(a > b));
          @(posedge clk);
          #1;
          expw = valid ? status_word(y, c, af, ov) : prev;
          check(valid ? "R6 R7 R8 R9 status word" : "R4 idle holds flags",
                int'(flags_o), expw);
        end
      end
    end

    // R6: capture a known word, then hold it with flag_we low
    @(negedge clk);
    opa = 8'h7F; opb = 8'h01; fsel = 3'b000; flag_we = 1'b1;
    @(posedge clk); #1;
    check("R9 R8 add 7F+01", int'(flags_o), 'h0890);
    @(negedge clk);
    opa = 8'h00; opb = 8'h00; fsel = 3'b011; flag_we = 1'b0;
    @(posedge clk); #1;
    check("R6 we low hold", int'(flags_o), 'h0890);

    // R10: control bits via strobes only
    @(negedge clk);
    ctl_set = 3'b001;
    @(posedge clk); #1;
    check("R10 set trap", int'(flags_o[10:8]), 1);
    @(negedge clk);
    ctl_set = 3'b110;
    @(posedge clk); #1;
    check("R10 set int/dir", int'(flags_o[10:8]), 7);
    @(negedge clk);
    ctl_set = 3'b000; flag_we = 1'b1; fsel = 3'b011; opa = 8'h00; opb = 8'h00;
    @(posedge clk); #1;
    check("R10 flag_we leaves control", int'(flags_o[10:8]), 7);
    check("R5 word layout after AND 0", int'(flags_o), 'h0744);
    @(negedge clk);
    flag_we = 1'b0; ctl_set = 3'b010; ctl_clr = 3'b011;
    @(posedge clk); #1;
    check("R10 clear wins", int'(flags_o[10:8]), 4);
    @(negedge clk);
    ctl_set = 3'b000; ctl_clr = 3'b000;
    @(posedge clk); #1;
    check("R10 hold", int'(flags_o[10:8]), 4);

    // R5: asynchronous reset clears the whole word
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R5 reset clears", int'(flags_o), 0);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule